// File: doc/BRIEF.md
# Paged Memory Translator with Write Protection

This block sits between an 8-bit processor and a large physical memory. Each 16-bit logical address is turned into a 24-bit physical address. The upper logical bits pick one entry from a table of mapping registers, and that entry supplies the physical page number. Two sets of entries exist, one per task, and a control bit chooses which set is live. Pages are 8kB by default. A control bit switches to 4kB pages, which doubles the number of entries each task uses.

Every entry also carries a protect flag. A processor write that lands on a protected page never reaches memory, because the memory write strobe stays low. The attempt instead sets a sticky interrupt flag. Software clears that flag by writing a one to the status location.

The mapping table and the control bits are programmed through a small register port, and every location of that port can be read back. Translation is combinational within the processor cycle, and register changes apply from the next cycle.

Top module: `pmmu_top`

## Requirements
- R1: After reset every entry of both tasks holds its own slot number (entry k holds k modulo 16) with the protect flag clear. The control register is 0, meaning 8kB pages and task 0, and the interrupt is low. In this state the physical address equals the logical address, zero-extended.
- R2: With control bit 0 = 0 (8kB pages), entry slot = addr[15:13] and phys = {entry[10:0], addr[12:0]}.
- R3: With control bit 0 = 1 (4kB pages), entry slot = addr[15:12] and phys = {entry[11:0], addr[11:0]}.
- R4: Control bit 1 selects the task. Task t uses register-port locations t*16 + slot, where the locations 0..31 hold the entries.
- R5: Entry bit 15 is the protect flag. When the selected entry has it set, mem_we is 0. Otherwise mem_we equals cpu_we.
- R6: A processor write to a protected page sets irq on the next clock edge. irq then stays high until it is cleared.
- R7: Writing location 0x21 with data bit 0 = 1 clears irq. Writing it with bit 0 = 0 has no effect. If a blocked write arrives in the same cycle as a clear, the set wins.
- R8: A register-port write changes the translation from the clock edge that accepts it, and not before. Entry bits 14..12 (4kB mode) and bits 14..11 (8kB mode) do not affect the physical address.
- R9: cfg_rdata returns the addressed location as it is now held:
  - locations 0..31 return the entries;
  - 0x20 returns the control register in bits 1:0;
  - 0x21 returns irq in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Logical address |
| cpu_we | input | 1 | Processor write strobe |
| phys_addr | output | 24 | Translated physical address |
| mem_we | output | 1 | Memory write strobe, gated by the protect flag |
| cfg_we | input | 1 | Register-port write strobe |
| cfg_addr | input | 6 | Register-port location |
| cfg_wdata | input | 16 | Register-port write data |
| cfg_rdata | output | 16 | Register-port read data |
| irq | output | 1 | Sticky protection-violation interrupt |

## Verification
The assertions assume that cpu_we and cfg_we are valid once per clock. They also assume that the only cause of a low mem_we during a processor write is the protect flag. The stimulus holds to this by changing inputs just after a rising edge. It raises cpu_we only for one-cycle accesses, and it issues clears through the register port only at known points. Sweeps cover both page sizes and both tasks with mapping values computed in the bench.

// File: rtl/pmmu_pkg.sv
package pmmu_pkg;
  localparam int LA_W_DEF   = 16;
  localparam int PA_W_DEF   = 24;
  localparam int REG_W_DEF  = 16;
  localparam int SLOT_W_DEF = 4;
  localparam int TASK_W_DEF = 1;

  typedef struct packed {
    logic task_sel;
    logic fine_pages;
  } ctrl_t;
endpackage

// File: rtl/pmmu_regfile.sv
module pmmu_regfile #(
  parameter int REG_W  = 16,
  parameter int IDX_W  = 5,
  parameter int SLOT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [REG_W-1:0] wdata,
  input  logic [IDX_W-1:0] xidx,
  output logic [REG_W-1:0] xdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [REG_W-1:0] rdata
);
  localparam int NREG  = 1 << IDX_W;
  localparam int SLOTS = 1 << SLOT_W;

  logic [REG_W-1:0] tbl [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) tbl[i] <= REG_W'(i % SLOTS);
    end else if (we) begin
      tbl[widx] <= wdata;
    end
  end

  assign xdata = tbl[xidx];
  assign rdata = tbl[ridx];
endmodule

// File: rtl/pmmu_xlate.sv
module pmmu_xlate #(
  parameter int LA_W   = 16,
  parameter int PA_W   = 24,
  parameter int REG_W  = 16,
  parameter int SLOT_W = 4,
  parameter int TASK_W = 1
) (
  input  logic                     fine_pages,
  input  logic [TASK_W-1:0]        task_sel,
  input  logic [LA_W-1:0]          cpu_addr,
  input  logic [REG_W-1:0]         entry,
  output logic [TASK_W+SLOT_W-1:0] idx,
  output logic [PA_W-1:0]          phys,
  output logic                     ro
);
  localparam int OFS_F = LA_W - SLOT_W;
  localparam int OFS_C = OFS_F + 1;
  localparam int PN_F  = PA_W - OFS_F;
  localparam int PN_C  = PA_W - OFS_C;

  logic [SLOT_W-1:0] slot;

  always_comb begin
    if (fine_pages) begin
      slot = cpu_addr[LA_W-1 -: SLOT_W];
      phys = {entry[PN_F-1:0], cpu_addr[OFS_F-1:0]};
    end else begin
      slot = {1'b0, cpu_addr[LA_W-1 -: SLOT_W-1]};
      phys = {entry[PN_C-1:0], cpu_addr[OFS_C-1:0]};
    end
  end

  assign idx = {task_sel, slot};
  assign ro  = entry[REG_W-1];
endmodule

// File: rtl/pmmu_irq.sv
module pmmu_irq (
  input  logic clk,
  input  logic rst,
  input  logic violate,
  input  logic clear,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (rst)          pending <= 1'b0;
    else if (violate) pending <= 1'b1;
    else if (clear)   pending <= 1'b0;
  end
endmodule

// File: rtl/pmmu_top.sv
module pmmu_top
  import pmmu_pkg::*;
#(
  parameter int LA_W   = LA_W_DEF,
  parameter int PA_W   = PA_W_DEF,
  parameter int REG_W  = REG_W_DEF,
  parameter int SLOT_W = SLOT_W_DEF,
  parameter int TASK_W = TASK_W_DEF,
  localparam int IDX_W = TASK_W + SLOT_W,
  localparam int CA_W  = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LA_W-1:0]  cpu_addr,
  input  logic             cpu_we,
  output logic [PA_W-1:0]  phys_addr,
  output logic             mem_we,
  input  logic             cfg_we,
  input  logic [CA_W-1:0]  cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             irq
);
  ctrl_t            ctrl;
  logic [IDX_W-1:0] xidx;
  logic [REG_W-1:0] xentry, rentry;
  logic             ro, hit_misc, tbl_we, irq_clr;

  assign hit_misc = cfg_addr[CA_W-1];
  assign tbl_we   = cfg_we && !hit_misc;
  assign irq_clr  = cfg_we && hit_misc && cfg_addr[0] && cfg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (cfg_we && hit_misc && !cfg_addr[0]) ctrl <= ctrl_t'(cfg_wdata[1:0]);
  end

  pmmu_regfile #(.REG_W(REG_W), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) rf_i (
    .clk(clk), .rst(rst), .we(tbl_we), .widx(cfg_addr[IDX_W-1:0]),
    .wdata(cfg_wdata), .xidx(xidx), .xdata(xentry),
    .ridx(cfg_addr[IDX_W-1:0]), .rdata(rentry)
  );

  pmmu_xlate #(.LA_W(LA_W), .PA_W(PA_W), .REG_W(REG_W), .SLOT_W(SLOT_W),
               .TASK_W(TASK_W)) xl_i (
    .fine_pages(ctrl.fine_pages), .task_sel(TASK_W'(ctrl.task_sel)),
    .cpu_addr(cpu_addr), .entry(xentry), .idx(xidx), .phys(phys_addr), .ro(ro)
  );

  assign mem_we = cpu_we && !ro;

  pmmu_irq irq_i (
    .clk(clk), .rst(rst), .violate(cpu_we && ro), .clear(irq_clr), .pending(irq)
  );

  always_comb begin
    if (!hit_misc)       cfg_rdata = rentry;
    else if (cfg_addr[0]) cfg_rdata = REG_W'(irq);
    else                  cfg_rdata = REG_W'(ctrl);
  end
endmodule

// File: rtl/pmmu_chk.sv
module pmmu_chk #(
  parameter int LA_W = 16,
  parameter int PA_W = 24,
  parameter int CA_W = 6,
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [LA_W-1:0]  cpu_addr,
  input logic             cpu_we,
  input logic [PA_W-1:0]  phys_addr,
  input logic             mem_we,
  input logic             cfg_we,
  input logic [CA_W-1:0]  cfg_addr,
  input logic [REG_W-1:0] cfg_wdata,
  input logic             irq
);
  logic clr_req;
  assign clr_req = cfg_we && cfg_addr == {1'b1, {(CA_W-2){1'b0}}, 1'b1} && cfg_wdata[0];

  AST_WE_GATED: assert property (@(posedge clk) disable iff (rst) mem_we |-> cpu_we); // R5
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    phys_addr[LA_W-5:0] == cpu_addr[LA_W-5:0]); // R3
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && !mem_we) |=> irq); // R6
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !irq ##1 irq |-> $past(cpu_we && !mem_we)); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_req) |=> irq); // R7
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !(cpu_we && !mem_we)) |=> !irq); // R7
endmodule

bind pmmu_top pmmu_chk #(.LA_W(LA_W), .PA_W(PA_W), .CA_W(CA_W), .REG_W(REG_W)) chk_i (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .phys_addr(phys_addr),
  .mem_we(mem_we), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .irq(irq)
);

// File: tb/pmmu_top_tb_top.sv
module pmmu_top_tb_top;
  logic        clk = 0, rst = 1;
  logic [15:0] cpu_addr = 0;
  logic        cpu_we = 0;
  logic [23:0] phys_addr;
  logic        mem_we;
  logic        cfg_we = 0;
  logic [5:0]  cfg_addr = 0;
  logic [15:0] cfg_wdata = 0;
  logic [15:0] cfg_rdata;
  logic        irq;

  int total = 0, bad = 0;
  logic [15:0] model [32];

  always #4 clk = ~clk;

  pmmu_top dut_i (.clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .phys_addr(phys_addr), .mem_we(mem_we), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [5:0] a, logic [15:0] d);
    @(posedge clk); #1;
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  function automatic logic [23:0] exp_phys(logic fine, logic t, logic [15:0] a);
    logic [15:0] e;
    if (fine) begin
      e = model[{t, a[15:12]}];
      return {e[11:0], a[11:0]};
    end
    e = model[{t, 1'b0, a[15:13]}];
    return {e[10:0], a[12:0]};
  endfunction

  function automatic logic exp_ro(logic fine, logic t, logic [15:0] a);
    if (fine) return model[{t, a[15:12]}][15];
    return model[{t, 1'b0, a[15:13]}][15];
  endfunction

  task automatic sweep(logic fine, logic t, string req);
    for (int a = 0; a < 65536; a += 251) begin
      cpu_addr = 16'(a); #1;
      check(req, phys_addr, exp_phys(fine, t, 16'(a)));
    end
    for (int p = 0; p < 16; p++) begin
      cpu_addr = 16'(p * 4096 + 4095); #1;
      check(req, phys_addr, exp_phys(fine, t, cpu_addr));
    end
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset contents and identity mapping
    for (int i = 0; i < 32; i++) begin
      model[i] = 16'(i % 16);
      cfg_addr = 6'(i); #1;
      check("R1", cfg_rdata, model[i]);
    end
    cfg_addr = 6'h20; #1; check("R1", cfg_rdata, 0);
    cfg_addr = 6'h21; #1; check("R1", cfg_rdata, 0);
    check("R1", irq, 0);
    for (int a = 0; a < 65536; a += 127) begin
      cpu_addr = 16'(a); cpu_we = 1; #1;
      check("R1", phys_addr, 24'(a));
      check("R1", mem_we, 1);
    end
    cpu_we = 0;
    // program both tasks; bit 15 protect on some entries, bits 14..11 vary (R8)
    for (int i = 0; i < 32; i++) begin
      model[i] = 16'((i * 1237 + 3) & 16'h7FFF) | ((i % 5 == 1) ? 16'h8000 : 16'h0);
      cfg_write(6'(i), model[i]);
    end
    // R9 readback
    for (int i = 0; i < 32; i++) begin
      cfg_addr = 6'(i); #1;
      check("R9", cfg_rdata, model[i]);
    end
    // R2 coarse pages, task 0; R4 task 1
    sweep(0, 0, "R2");
    cfg_write(6'h20, 16'h0002);
    cfg_addr = 6'h20; #1; check("R9", cfg_rdata, 2);
    sweep(0, 1, "R4");
    cfg_write(6'h20, 16'h0003);
    sweep(1, 1, "R4");
    cfg_write(6'h20, 16'h0001);
    sweep(1, 0, "R3");
    // R8 timing: write entry 3 of task 0 (fine mode), phys changes only after the edge
    cpu_addr = 16'h3ABC;
    @(posedge clk); #1;
    cfg_we = 1; cfg_addr = 6'd3; cfg_wdata = 16'h7456;
    #2; check("R8", phys_addr, exp_phys(1, 0, 16'h3ABC));
    @(posedge clk); #1; cfg_we = 0;
    model[3] = 16'h7456;
    check("R8", phys_addr, 24'h456ABC);
    // R5 / R6 protection across both modes
    for (int m = 0; m < 2; m++) begin
      cfg_write(6'h20, 16'(m));
      cfg_write(6'h21, 16'h0001);
      check("R7", irq, 0);
      for (int p = 0; p < 16; p++) begin
        logic r;
        cpu_addr = 16'(p * 4096 + 17);
        r = exp_ro(m[0], 0, cpu_addr);
        @(posedge clk); #1;
        cpu_we = 1; #1;
        check("R5", mem_we, !r);
        @(posedge clk); #1;
        cpu_we = 0;
        if (r) check("R6", irq, 1);
        cfg_write(6'h21, 16'h0001);
      end
    end
    // R6 sticky, R7 zero write ignored
    cfg_write(6'h20, 16'h0000);
    cpu_addr = 16'h2000; // slot 1 protected
    @(posedge clk); #1; cpu_we = 1;
    @(posedge clk); #1; cpu_we = 0;
    check("R6", irq, 1);
    repeat (4) @(posedge clk);
    #1 check("R6", irq, 1);
    cfg_write(6'h21, 16'h0000);
    check("R7", irq, 1);
    cfg_addr = 6'h21; #1; check("R9", cfg_rdata, 1);
    // R7 set wins over simultaneous clear
    @(posedge clk); #1;
    cpu_we = 1; cfg_we = 1; cfg_addr = 6'h21; cfg_wdata = 16'h0001;
    @(posedge clk); #1;
    cpu_we = 0; cfg_we = 0;
    check("R7", irq, 1);
    cfg_write(6'h21, 16'h0001);
    check("R7", irq, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule